// File: doc/BRIEF.md
# Receive Frame Broadcast and VLAN Tag Classifier

This block sits beside a receive path and looks at the first bytes of each incoming Ethernet frame. It takes them as a byte stream with a valid strobe, a first-byte marker and a last-byte marker. It works out three things. It checks whether the destination address is the all-ones broadcast address. It checks whether the frame carries an IEEE 802.1Q tag in the type position. If there is a tag, it checks whether the tag is a priority-only tag, which has a zero VLAN identifier. It also extracts the 3-bit priority and the CFI bit from the tag.

The results appear in the upper half of a 32-bit receive status word, in fixed bit positions. A one-cycle done pulse marks the moment they become valid. The results then hold until the next frame begins. Whatever builds the rest of the status word ORs these bits into it.

Top module: `rx_vlan_bcast_class`

## Requirements
- R1: After reset, `status_o` is all zeros and `done_o` is low.
- R2: A byte accepted with `sof_i` high, and without `eof_i`, clears every classification bit in `status_o` on the next cycle.
- R3: Bit 31 of `status_o` is set when frame bytes 0 to 5 (the destination address) are all 8'hFF. A single byte that differs leaves bit 31 clear.
- R4: Bit 21 is set when bytes 12 and 13 form the type value 16'h8100, with byte 12 as the most significant byte.
- R5: Bit 20 is set when bit 21 is set and the 12-bit VLAN identifier is zero. The identifier is bits 11:0 of the tag control word, which is formed from bytes 14 (high) and 15 (low).
- R6: With a tag present, bits 19:17 carry the tag control word's bits 15:13 (the priority), and bit 16 carries its bit 12 (CFI).
- R7: When bit 21 is clear, bits 20 down to 16 are all zero.
- R8: `done_o` is high for exactly the one cycle that follows acceptance of byte 15. `status_o` holds the final result in that cycle.
- R9: If a frame ends before byte 15, `done_o` pulses in the cycle after the last byte. In that case bit 31 is set only if all six address bytes were seen as 8'hFF, and bits 21 to 16 are zero.
- R10: Between the done pulse and the next `sof_i`, `status_o` does not change. In that interval, later bytes, a later `eof_i` and idle cycles cause no further `done_o` pulse.
- R11: Bits 30:22 and 15:0 of `status_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A byte is present on `byte_i` this cycle |
| byte_i | input | 8 | Received frame byte |
| sof_i | input | 1 | This byte is frame byte 0; qualified by `byte_valid_i` |
| eof_i | input | 1 | This byte is the last byte of the frame; qualified by `byte_valid_i` |
| done_o | output | 1 | One-cycle pulse: the classification is final |
| status_o | output | 32 | Status word holding the classification bits |

## Verification
The bench sends several kinds of frame:
- A broadcast untagged frame and a unicast tagged frame, which separate address detection from tag detection.
- A broadcast frame with a priority-only tag and the CFI bit set, which separates the identifier-zero case from a full tag and exercises every priority bit.
- Near misses: a type of 16'h8101, and an address whose last byte is 8'hFE. These show that a match needs every bit.
- Short frames of 4, 10 and 14 bytes, which check where the done pulse falls and which partial results stay.
- Stray bytes after the done pulse, which show that the held result is not disturbed.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned STAT_W   = 32;
  // status word bit positions consumed by the status assembler
  localparam int unsigned BC_BIT   = 31;
  localparam int unsigned VLAN_BIT = 21;
  localparam int unsigned PRIO_BIT = 20;
  localparam int unsigned PCP_LSB  = 17;
  localparam int unsigned CFI_BIT  = 16;

  typedef struct packed {
    logic       bcast;
    logic       vlan;
    logic       prio_only;
    logic [2:0] pcp;
    logic       cfi;
  } class_t;
endpackage

// File: rtl/rxc_hdr_pos.sv
module rxc_hdr_pos #(
  parameter int unsigned HDR_LEN = 16,
  localparam int unsigned IDX_W  = $clog2(HDR_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_hdr_o,
  output logic             end_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o   = byte_valid_i && (sof_i || active_q);
  assign idx_o      = sof_i ? '0 : idx_q;
  assign last_hdr_o = accept_o && (idx_o == IDX_W'(HDR_LEN - 1));
  assign end_o      = accept_o && (eof_i || last_hdr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (end_o) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      idx_q    <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/rxc_bcast_det.sv
module rxc_bcast_det #(
  parameter int unsigned DA_LEN = 6,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      accept_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [rxc_pkg::BYTE_W-1:0] byte_i,
  output logic                      bcast_o
);
  logic run_q;
  logic ones;

  assign ones = &byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (accept_i) begin
      if (idx_i == '0)                      run_q <= ones;
      else if (idx_i < IDX_W'(DA_LEN))      run_q <= run_q & ones;
    end
  end

  // result for an end event at the current byte
  always_comb begin
    if (idx_i >= IDX_W'(DA_LEN))            bcast_o = run_q;
    else if (idx_i == IDX_W'(DA_LEN - 1))   bcast_o = run_q & ones;
    else                                    bcast_o = 1'b0;
  end
endmodule

// File: rtl/rxc_tag_parse.sv
module rxc_tag_parse #(
  parameter int unsigned   TYPE_POS = 12,
  parameter int unsigned   IDX_W    = 5,
  parameter logic [15:0]   TPID     = 16'h8100
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       accept_i,
  input  logic                       last_hdr_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [rxc_pkg::BYTE_W-1:0] byte_i,
  output logic                       vlan_o,
  output logic                       prio_only_o,
  output logic [2:0]                 pcp_o,
  output logic                       cfi_o
);
  logic [15:0] type_q;
  logic [7:0]  tci_hi_q;
  logic [15:0] tci;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q   <= '0;
      tci_hi_q <= '0;
    end else if (accept_i) begin
      if (idx_i == IDX_W'(TYPE_POS))     type_q[15:8] <= byte_i;
      if (idx_i == IDX_W'(TYPE_POS + 1)) type_q[7:0]  <= byte_i;
      if (idx_i == IDX_W'(TYPE_POS + 2)) tci_hi_q     <= byte_i;
    end
  end

  assign tci         = {tci_hi_q, byte_i};
  assign vlan_o      = last_hdr_i && (type_q == TPID);
  assign prio_only_o = vlan_o && (tci[11:0] == 12'h000);
  assign pcp_o       = vlan_o ? tci[15:13] : 3'b000;
  assign cfi_o       = vlan_o & tci[12];
endmodule

// File: rtl/rx_vlan_bcast_class.sv
module rx_vlan_bcast_class #(
  parameter int unsigned DA_LEN   = 6,
  parameter int unsigned TYPE_POS = 12,
  parameter logic [15:0] TPID     = 16'h8100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        sof_i,
  input  logic        eof_i,
  output logic        done_o,
  output logic [31:0] status_o
);
  import rxc_pkg::*;

  localparam int unsigned HDR_LEN = TYPE_POS + 4;
  localparam int unsigned IDX_W   = $clog2(HDR_LEN + 1);

  logic             accept, last_hdr, end_evt;
  logic [IDX_W-1:0] idx;
  class_t           cls_d, cls_q;
  logic             done_q;

  rxc_hdr_pos #(.HDR_LEN(HDR_LEN)) u_pos (
    .clk_i, .rst_ni, .byte_valid_i, .sof_i, .eof_i,
    .accept_o(accept), .idx_o(idx), .last_hdr_o(last_hdr), .end_o(end_evt)
  );

  rxc_bcast_det #(.DA_LEN(DA_LEN), .IDX_W(IDX_W)) u_bc (
    .clk_i, .rst_ni, .accept_i(accept), .idx_i(idx), .byte_i,
    .bcast_o(cls_d.bcast)
  );

  rxc_tag_parse #(.TYPE_POS(TYPE_POS), .IDX_W(IDX_W), .TPID(TPID)) u_tag (
    .clk_i, .rst_ni, .accept_i(accept), .last_hdr_i(last_hdr), .idx_i(idx),
    .byte_i, .vlan_o(cls_d.vlan), .prio_only_o(cls_d.prio_only),
    .pcp_o(cls_d.pcp), .cfi_o(cls_d.cfi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_evt;
      if (end_evt)               cls_q <= cls_d;
      else if (accept && sof_i)  cls_q <= '0;
    end
  end

  always_comb begin
    status_o                      = '0;
    status_o[BC_BIT]              = cls_q.bcast;
    status_o[VLAN_BIT]            = cls_q.vlan;
    status_o[PRIO_BIT]            = cls_q.prio_only;
    status_o[PCP_LSB +: 3]        = cls_q.pcp;
    status_o[CFI_BIT]             = cls_q.cfi;
  end

  assign done_o = done_q;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        byte_valid_i,
  input logic        sof_i,
  input logic        eof_i,
  input logic        done_o,
  input logic [31:0] status_o
);
  assert_clear_on_sof_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && sof_i && !eof_i) |=> (status_o == 32'h0));

  assert_no_tag_fields_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[21] |-> (status_o[20:16] == 5'b0));

  assert_unused_bits_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[30:22] == 9'b0) && (status_o[15:0] == 16'b0));

  assert_hold_until_sof_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(byte_valid_i && sof_i) && !done_o) |-> $stable(status_o));
endmodule

bind rx_vlan_bcast_class rxc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .sof_i(sof_i),
  .eof_i(eof_i), .done_o(done_o), .status_o(status_o)
);

// File: tb/sim_rx_vlan_bcast_class.sv
module sim_rx_vlan_bcast_class;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        sof_i = 1'b0;
  logic        eof_i = 1'b0;
  logic        done_o;
  logic [31:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  rx_vlan_bcast_class u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one byte for one cycle; returns at the following negedge
  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk_i);
    byte_valid_i = 1'b1; byte_i = b; sof_i = s; eof_i = e;
    @(negedge clk_i);
    byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
  endtask

  function automatic logic [31:0] expect_word(input logic [47:0] da, input logic [15:0] typ,
                                               input logic [15:0] tci, input int len);
    logic [31:0] w = '0;
    logic tag = (len >= 16) && (typ == 16'h8100);
    w[31] = (len >= 6) && (da == 48'hFFFF_FFFF_FFFF);
    if (tag) begin
      w[21]    = 1'b1;
      w[20]    = (tci[11:0] == 12'h0);
      w[19:17] = tci[15:13];
      w[16]    = tci[12];
    end
    return w;
  endfunction

  function automatic logic [7:0] frame_byte(input logic [47:0] da, input logic [15:0] typ,
                                             input logic [15:0] tci, input int i);
    if (i < 6)   return da[47 - 8*i -: 8];
    if (i < 12)  return 8'h10 + 8'(i);
    if (i == 12) return typ[15:8];
    if (i == 13) return typ[7:0];
    if (i == 14) return tci[15:8];
    if (i == 15) return tci[7:0];
    return 8'(i * 3);
  endfunction

  task automatic run_frame(input string tag, input logic [47:0] da, input logic [15:0] typ,
                           input logic [15:0] tci, input int len);
    logic [31:0] exp = expect_word(da, typ, tci, len);
    int last = (len < 16) ? len - 1 : 15;
    logic [31:0] held;
    for (int i = 0; i < len; i++) begin
      put(frame_byte(da, typ, tci, i), i == 0, i == len - 1);
      if (i == last) begin
        chk({tag, " R8/R9 done"}, {31'b0, done_o}, 32'd1);
        chk({tag, " R3-R7 status"}, status_o, exp);
      end else begin
        chk({tag, " R8 no early done"}, {31'b0, done_o}, 32'd0);
        if (i == 0) chk({tag, " R2 cleared"}, status_o, 32'h0);
      end
    end
    held = status_o;
    @(negedge clk_i);
    chk({tag, " R10 no second done"}, {31'b0, done_o}, 32'd0);
    chk({tag, " R10 held"}, status_o, held);
  endtask

  task automatic t_reset;
    chk("R1 reset status", status_o, 32'h0);
    chk("R1 reset done", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_bcast_untagged;
    run_frame("R3 bcast untagged", 48'hFFFF_FFFF_FFFF, 16'h0800, 16'hE123, 20);
    chk("R7 untagged fields", {27'b0, status_o[20:16]}, 32'h0);
  endtask

  task automatic t_unicast_tagged;
    run_frame("R4 R6 unicast tag", 48'h0012_3456_789A, 16'h8100, 16'hA123, 20);
    chk("R4 vlan bit", {31'b0, status_o[21]}, 32'd1);
    chk("R5 not prio-only", {31'b0, status_o[20]}, 32'd0);
    chk("R6 pcp", {29'b0, status_o[19:17]}, 32'd5);
  endtask

  task automatic t_priority_tag;
    run_frame("R5 R6 prio tag", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'hF000, 18);
    chk("R5 prio-only bit", {31'b0, status_o[20]}, 32'd1);
    chk("R6 cfi", {31'b0, status_o[16]}, 32'd1);
  endtask

  task automatic t_near_miss;
    run_frame("R7 type 8101", 48'hFFFF_FFFF_FFFF, 16'h8101, 16'hE000, 16);
    run_frame("R3 da FE", 48'hFFFF_FFFF_FFFE, 16'h8100, 16'h2005, 16);
    chk("R3 bcast clear", {31'b0, status_o[31]}, 32'd0);
  endtask

  task automatic t_short;
    run_frame("R9 len10", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'h0000, 10);
    run_frame("R9 len4", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'h0000, 4);
    run_frame("R9 len14", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'h0000, 14);
    run_frame("R9 len1", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'h0000, 1);
  endtask

  task automatic t_stray;
    logic [31:0] held;
    run_frame("R10 base", 48'hFFFF_FFFF_FFFF, 16'h8100, 16'h6001, 16);
    held = status_o;
    put(8'h81, 1'b0, 1'b0);
    put(8'h00, 1'b0, 1'b1);
    chk("R10 stray no done", {31'b0, done_o}, 32'd0);
    put(8'hFF, 1'b0, 1'b1);
    chk("R10 stray held", status_o, held);
    chk("R11 unused zero", status_o & 32'h7FC0_FFFF, 32'h0);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_bcast_untagged;
    t_unicast_tagged;
    t_priority_tag;
    t_near_miss;
    t_short;
    t_stray;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule